// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial frame on a single output line. A byte enters through a valid/ready stream port into a one-entry holding register. When the shift engine is free and transmission is enabled, the byte moves into the engine. The engine then sends a start bit, 5 to 8 data bits, an optional parity bit and 1, 1.5 or 2 stop bits.

Bit timing comes from a transmit clock-enable input, `tick_en`. A mode byte selects one of three bit lengths: 1, 16 or 64 enable pulses per bit.

The frame format comes from an 8-bit mode word and can change between characters. The engine captures the format when a character starts, so a mode change never alters a frame already on the line. A break control forces the line low for as long as it is held. The block has two status flags. `s_ready` is high when the holding register is free. `tx_empty` is high when both the holding register and the engine are idle.

Back-pressure works as follows. A byte is taken on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` then stays low until that byte has moved into the engine. A source may hold `s_valid` high with stable data for as long as it likes. `s_ready` does not depend on `s_valid`, and `s_ready` does not depend on `tx_enable`.

Top module: `uart_async_tx`

## Requirements
- R1: After reset, and whenever no character is in flight and break is off, `txd` is 1. Right after reset, `s_ready` and `tx_empty` are both 1.
- R2: A byte is accepted on an edge with `s_valid` and `s_ready` both high. From the next cycle, `s_ready` is 0 until the byte moves into the shift engine. At most one byte waits.
- R3: A frame is a start bit of 0, then the data bits least significant first, then the parity bit if enabled, then stop bits at 1.
- R4: Mode bits 3:2 set the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are never sent.
- R5: Mode bit 4 set enables parity. Mode bit 5 set selects even parity, and clear selects odd parity. Parity covers only the selected data bits.
- R6: Mode bits 7:6 set the stop length: 01 gives 1 bit, 10 gives 1.5 bits and 11 gives 2 bits. 00 is treated as 1 bit.
- R7: Mode bits 1:0 set the ticks per bit: 01 gives 1, 10 gives 16 and 11 gives 64. 00 is treated as 1. A 1.5-bit stop lasts 24 or 96 ticks, and lasts 2 ticks in the 1-tick mode.
- R8: No character moves into the engine while `tx_enable` is 0. A frame that has already started runs to its end.
- R9: While `send_break` is 1, `txd` is 0. Frame timing carries on underneath.
- R10: The mode word is captured when a character moves into the engine. Later changes affect only later characters.
- R11: If a byte is waiting at the end of the last stop tick, its start bit begins on the next cycle with no idle gap. `tx_empty` is 1 only when both stages are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Transmit clock enable; one pulse is one tick |
| mode_word | input | 8 | Frame format: stop, parity, length, ticks per bit |
| tx_enable | input | 1 | Allows a new character to start |
| send_break | input | 1 | Forces the line to 0 |
| s_data | input | 8 | Character to send |
| s_valid | input | 1 | `s_data` is valid |
| s_ready | output | 1 | Holding register free |
| txd | output | 1 | Serial data line |
| tx_empty | output | 1 | Nothing held and nothing being shifted |

## Verification
A hand-off on a clock edge changes `s_ready` and `tx_empty` in the cycle right after that edge. The transfer into the engine puts the start bit on `txd` in that same next cycle. Each later bit changes `txd` one cycle after the edge that counts the last tick of the bit before it, and `send_break` acts on `txd` within the same cycle. The bench model advances on each rising edge using the inputs set at the preceding falling edge. It predicts all three outputs and compares them at every falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/utx_mode_decode.sv
module utx_mode_decode
  import utx_pkg::*;
#(
  parameter int unsigned MID_FACTOR = 16,
  parameter int unsigned HI_FACTOR  = 64,
  parameter int unsigned TICK_W     = 8
) (
  input  logic [7:0]        mode_word,
  output logic [IDX_W-1:0]  last_idx,
  output logic              par_en,
  output logic              par_odd,
  output logic [TICK_W-1:0] bit_ticks,
  output logic [TICK_W-1:0] stop_ticks
);
  localparam logic [TICK_W-1:0] ONE_T = TICK_W'(1);
  localparam logic [TICK_W-1:0] MID_T = TICK_W'(MID_FACTOR);
  localparam logic [TICK_W-1:0] HI_T  = TICK_W'(HI_FACTOR);

  // length code 00..11 maps to last index 4..7
  assign last_idx = IDX_W'(4) + IDX_W'(mode_word[3:2]);
  assign par_en   = mode_word[4];
  assign par_odd  = ~mode_word[5];

  always_comb begin
    unique case (mode_word[1:0])
      2'b10:   bit_ticks = MID_T;
      2'b11:   bit_ticks = HI_T;
      default: bit_ticks = ONE_T;
    endcase
  end

  always_comb begin
    unique case (mode_word[7:6])
      2'b10: begin
        if (bit_ticks == ONE_T) stop_ticks = TICK_W'(2);
        else                    stop_ticks = bit_ticks + (bit_ticks >> 1);
      end
      2'b11:   stop_ticks = bit_ticks << 1;
      default: stop_ticks = bit_ticks;
    endcase
  end
endmodule

// File: rtl/utx_hold_reg.sv
module utx_hold_reg
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] held
);
  assign in_ready = ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      held <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/utx_frame_engine.sv
module utx_frame_engine
  import utx_pkg::*;
#(
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              start_ok,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [TICK_W-1:0] bit_ticks,
  input  logic [TICK_W-1:0] stop_ticks,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);
  tx_state_e          state;
  logic [TICK_W-1:0]  cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  shreg;
  logic               par_q;
  logic [IDX_W-1:0]   last_q;
  logic               par_en_q;
  logic [TICK_W-1:0]  bit_q;
  logic [TICK_W-1:0]  stop_q;

  logic [TICK_W-1:0]  cur_len;
  logic               bit_done;
  logic               frame_end;
  logic               par_calc;
  logic [DATA_W-1:0]  sel_mask;

  // parity over selected bits only
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sel_mask[g] = (IDX_W'(g) <= last_idx);
  end
  assign par_calc = (^(byte_in & sel_mask)) ^ par_odd;

  assign cur_len   = (state == ST_STOP) ? stop_q : bit_q;
  assign bit_done  = tick_en && (cnt == cur_len - TICK_W'(1));
  assign frame_end = (state == ST_STOP) && bit_done;
  assign take      = start_ok && ((state == ST_IDLE) || frame_end);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      last_q   <= '0;
      par_en_q <= 1'b0;
      bit_q    <= TICK_W'(1);
      stop_q   <= TICK_W'(1);
    end else if (take) begin
      state    <= ST_START;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= byte_in;
      par_q    <= par_calc;
      last_q   <= last_idx;
      par_en_q <= par_en;
      bit_q    <= bit_ticks;
      stop_q   <= stop_ticks;
    end else if (busy && tick_en) begin
      if (bit_done) begin
        cnt <= '0;
        unique case (state)
          ST_START: begin
            state <= ST_DATA;
            idx   <= '0;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (idx == last_q) state <= par_en_q ? ST_PAR : ST_STOP;
            else               idx   <= idx + IDX_W'(1);
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + TICK_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_async_tx.sv
module uart_async_tx
  import utx_pkg::*;
#(
  parameter int unsigned MID_FACTOR = 16,
  parameter int unsigned HI_FACTOR  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] mode_word,
  input  logic       tx_enable,
  input  logic       send_break,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  output logic       s_ready,
  output logic       txd,
  output logic       tx_empty
);
  localparam int unsigned TICK_W = $clog2(2 * HI_FACTOR + 1);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              line_bit;
  logic [IDX_W-1:0]  last_idx;
  logic              par_en;
  logic              par_odd;
  logic [TICK_W-1:0] bit_ticks;
  logic [TICK_W-1:0] stop_ticks;

  utx_mode_decode #(
    .MID_FACTOR(MID_FACTOR),
    .HI_FACTOR (HI_FACTOR),
    .TICK_W    (TICK_W)
  ) u_dec (
    .mode_word (mode_word),
    .last_idx  (last_idx),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .bit_ticks (bit_ticks),
    .stop_ticks(stop_ticks)
  );

  utx_hold_reg u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(s_valid),
    .in_data (s_data),
    .in_ready(s_ready),
    .take    (take),
    .full    (hold_full),
    .held    (hold_data)
  );

  utx_frame_engine #(.TICK_W(TICK_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .start_ok  (hold_full && tx_enable),
    .byte_in   (hold_data),
    .last_idx  (last_idx),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .bit_ticks (bit_ticks),
    .stop_ticks(stop_ticks),
    .take      (take),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  assign txd      = send_break ? 1'b0 : line_bit;
  assign tx_empty = ~busy & ~hold_full;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_enable,
  input logic send_break,
  input logic s_valid,
  input logic s_ready,
  input logic txd,
  input logic tx_empty
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !send_break) |-> txd);

  assert_hold_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_hold_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !s_ready) |=> !s_ready);

  assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && tx_empty && !s_valid) |=> tx_empty);

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |-> !txd);

  assert_empty_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> s_ready);
endmodule

bind uart_async_tx utx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_enable (tx_enable),
  .send_break(send_break),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .txd       (txd),
  .tx_empty  (tx_empty)
);

// File: tb/tb_uart_async_tx.sv
module tb_uart_async_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [7:0] mode_word = 8'h4D;
  logic       tx_enable = 1'b0;
  logic       send_break = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_ready, txd, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_async_tx dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_word(mode_word),
    .tx_enable(tx_enable), .send_break(send_break), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .txd(txd), .tx_empty(tx_empty)
  );

  // behavioural reference: a queue of (level, ticks) per frame
  bit  m_full = 0;
  bit  [7:0] m_data = 0;
  bit  m_busy = 0;
  int  m_rem = 0;
  bit  lv[$];
  int  du[$];

  function automatic void build_frame(bit [7:0] d, bit [7:0] m);
    int nb, L, st;
    bit p;
    nb = 5 + int'(m[3:2]);
    L  = (m[1:0] == 2'b10) ? 16 : (m[1:0] == 2'b11) ? 64 : 1;
    case (m[7:6])
      2'b10:   st = (L == 1) ? 2 : L + L / 2;
      2'b11:   st = 2 * L;
      default: st = L;
    endcase
    lv.delete(); du.delete();
    lv.push_back(1'b0); du.push_back(L);
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      lv.push_back(d[i]); du.push_back(L);
      p = p ^ d[i];
    end
    if (m[4]) begin
      lv.push_back(m[5] ? p : ~p); du.push_back(L);
    end
    lv.push_back(1'b1); du.push_back(st);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_rem = 0; lv.delete(); du.delete();
    end else begin
      bit old_full, load;
      old_full = m_full;
      if (m_busy && tick_en) begin
        m_rem--;
        if (m_rem == 0) begin
          void'(lv.pop_front()); void'(du.pop_front());
          if (lv.size() == 0) m_busy = 0;
          else m_rem = du[0];
        end
      end
      load = !m_busy && old_full && tx_enable;
      if (load) begin
        build_frame(m_data, mode_word);
        m_busy = 1; m_rem = du[0];
      end
      if (s_valid && !old_full) begin
        m_full = 1; m_data = s_data;
      end else if (load) begin
        m_full = 0;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_txd;
      e_txd = send_break ? 1'b0 : (m_busy ? lv[0] : 1'b1);
      check(cur_req, "txd", int'(txd), int'(e_txd));
      check(cur_req, "s_ready", int'(s_ready), int'(!m_full));
      check(cur_req, "tx_empty", int'(tx_empty), int'(!m_busy && !m_full));
    end
  end

  // tick generator
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tick_en = (c % tick_div) == 0;
    end
  end

  task automatic send(bit [7:0] d);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "reset txd", int'(txd), 1);
    check("R1", "reset s_ready", int'(s_ready), 1);
    check("R1", "reset tx_empty", int'(tx_empty), 1);

    // R3, R11: 8 data, no parity, 1 stop, 1x, back to back
    cur_req = "R3_R11"; tx_enable = 1'b1; mode_word = 8'h4D; tick_div = 1;
    send(8'hA5); send(8'h3C); send(8'h81);
    wait_idle();

    // R2: ready low while holding, slow ticks
    cur_req = "R2"; tick_div = 3;
    send(8'h5A); send(8'hC3);
    wait_idle();

    // R4, R5: 7 data, even parity, 16x; high bit must be ignored
    cur_req = "R4_R5"; mode_word = 8'h7A; tick_div = 1;
    send(8'hD5); send(8'h55);
    wait_idle();

    // R5, R6, R7: 5 data, odd parity, 2 stop, 64x, tick every 2 cycles
    cur_req = "R5_R6_R7"; mode_word = 8'hD3; tick_div = 2;
    send(8'h1F); send(8'hE0);
    wait_idle();

    // R6, R7: 6 data, 1.5 stop, 16x then 1x
    cur_req = "R6_R7"; mode_word = 8'h86; tick_div = 1;
    send(8'h2B);
    wait_idle();
    mode_word = 8'h85;
    send(8'h2B); send(8'h14);
    wait_idle();

    // R6: stop code 00 -> 1 stop; R7: factor 00 -> 1x
    cur_req = "R6"; mode_word = 8'h0D;
    send(8'h96);
    wait_idle();
    cur_req = "R7"; mode_word = 8'h4C;
    send(8'h69);
    wait_idle();

    // R8: no start without enable, running frame completes
    cur_req = "R8"; mode_word = 8'h7A; tx_enable = 1'b0;
    send(8'h42);
    repeat (40) @(negedge clk);
    check("R8", "held byte not started txd", int'(txd), 1);
    check("R8", "held byte tx_empty", int'(tx_empty), 0);
    tx_enable = 1'b1;
    repeat (30) @(negedge clk);
    tx_enable = 1'b0;
    send(8'h77);
    repeat (300) @(negedge clk);
    check("R8", "second byte still held s_ready", int'(s_ready), 0);
    tx_enable = 1'b1;
    wait_idle();

    // R9: break while idle and mid frame
    cur_req = "R9"; send_break = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", "idle break txd", int'(txd), 0);
    send_break = 1'b0;
    send(8'hFF);
    repeat (20) @(negedge clk);
    send_break = 1'b1;
    repeat (40) @(negedge clk);
    send_break = 1'b0;
    wait_idle();

    // R10: mode change mid frame does not affect current frame
    cur_req = "R10"; mode_word = 8'hFE;
    send(8'hB7);
    repeat (25) @(negedge clk);
    mode_word = 8'h41;
    send(8'h0F);
    wait_idle();

    summary();
  end
endmodule